// File: doc/BRIEF.md
# CAN Single-Buffer Transmit Request Controller

This block drives the transmit side of a CAN controller while it runs with its message RAM bypassed. A small set of CPU-visible buffer registers then acts as the only transmit buffer. Software fills in the identifier, the length code and the payload. It then writes 1 to a busy flag to request transmission. From that point the buffer is frozen against CPU writes. The block waits until the bus is idle and then pulses a load strobe, so the CAN core copies the buffer into its shift register.

The core reports the outcome of each attempt with single-cycle pulses: done, arbitration lost or error. On success the busy flag clears and the buffer unlocks. On a lost arbitration or an error, a request that is still standing goes back to waiting for bus idle and loads the same buffer again.

Software can withdraw a request at any time by writing 0 to the busy flag. Once it has done so, no further attempt is made. If a frame is already on the wire at that moment, busy reads 0 at once, but the buffer stays locked until the core reports how that frame ended.

Top module: `can_txb_ctrl`

## Requirements
- R1: After reset, busy and locked are 0, load is 0 and every buffer register reads 0.
- R2: Writing a value with bit 0 set to the command register (address 0) sets busy and locks the buffer, but only while basic_mode_i is 1. With basic_mode_i at 0 such a write is ignored. Busy is read back on bit 0 of address 0.
- R3: Buffer registers take CPU writes only while unlocked. Writes while locked are discarded, and reads stay allowed. The buffer map is: address 1 holds the identifier in bits 28:0 and the extended-format flag in bit 30; address 2 holds the length code in bits 3:0; addresses 3 and 4 hold payload bits 31:0 and 63:32.
- R4: load_o is a one-cycle pulse that is raised only while a request waits, bus_idle_i is 1 and basic_mode_i is 1. The frame outputs equal the buffer contents.
- R5: A done pulse during a frame clears busy and unlocks the buffer on the next cycle.
- R6: An arbitration-lost or error pulse while busy is still 1 keeps busy and the lock. It raises no load in the same cycle, and it loads the same buffer again on a later cycle in which bus_idle_i is 1.
- R7: Writing 0 to busy while waiting for bus idle clears busy and unlocks on the next cycle, with no load, even if bus_idle_i is 1 in that cycle.
- R8: Writing 0 to busy while a frame is on the bus clears busy on the next cycle. The buffer stays locked until done, arbitration lost or error, and no further load follows.
- R9: Writing 0 to busy while it is 0 has no effect. Writing 1 while locked has no effect and starts no second load.
- R10: An abort that lands in the same cycle as a done, arbitration-lost or error pulse clears busy, unlocks on the next cycle and suppresses any retry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| basic_mode_i | input | 1 | Single-buffer mode enable from the test register |
| reg_wr_i | input | 1 | CPU register write strobe |
| reg_addr_i | input | ADDR_W (3) | CPU register address |
| reg_wdata_i | input | REG_W (32) | CPU write data |
| reg_rdata_o | output | REG_W (32) | CPU read data for reg_addr_i (combinational) |
| bus_idle_i | input | 1 | CAN bus idle indication from the core |
| load_o | output | 1 | Strobe: core loads its shift register from the frame outputs |
| tx_id_o | output | ID_W (29) | Frame identifier |
| tx_ext_o | output | 1 | Extended-format flag |
| tx_dlc_o | output | DLC_W (4) | Length code |
| tx_data_o | output | DATA_W (64) | Payload |
| done_i | input | 1 | Pulse: frame sent successfully |
| arb_lost_i | input | 1 | Pulse: arbitration lost |
| err_i | input | 1 | Pulse: transmission error |
| busy_o | output | 1 | Busy flag as seen by the CPU |
| locked_o | output | 1 | Buffer write lock |

## Verification
The interesting collision is a CPU write of 0 to the busy flag in the same cycle as a core outcome pulse, or in the same cycle as bus idle while a request waits. Directed cases place an abort on the cycle of an arbitration-lost pulse, and on the cycle in which bus_idle_i rises. A constrained-random phase sprays command writes and outcome pulses so that they collide often. Each collision is judged by comparing the next-cycle busy and lock states against a bench reference, and by confirming that no load pulse appears afterwards while the bus sits idle.

// File: rtl/can_txb_pkg.sv
package can_txb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_BUS   = 2'd2,
    ST_DRAIN = 2'd3
  } tx_state_e;

  localparam int unsigned ADR_CMD  = 0;
  localparam int unsigned ADR_ID   = 1;
  localparam int unsigned ADR_CTRL = 2;
  localparam int unsigned ADR_DATA = 3;
endpackage

// File: rtl/can_txb_regs.sv
module can_txb_regs
  import can_txb_pkg::*;
#(
  parameter int unsigned REG_W  = 32,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned ID_W   = 29,
  parameter int unsigned DLC_W  = 4,
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              lock_i,
  input  logic              busy_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [ID_W-1:0]   id_o,
  output logic              ext_o,
  output logic [DLC_W-1:0]  dlc_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned NWORDS  = DATA_W / REG_W;
  localparam int unsigned EXT_BIT = REG_W - 2;

  logic              wr_ok;
  logic [ID_W-1:0]   id_q;
  logic              ext_q;
  logic [DLC_W-1:0]  dlc_q;
  logic [DATA_W-1:0] data_q;

  assign wr_ok = wr_i && !lock_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q  <= '0;
      ext_q <= 1'b0;
      dlc_q <= '0;
    end else begin
      if (wr_ok && addr_i == ADDR_W'(ADR_ID)) begin
        id_q  <= wdata_i[ID_W-1:0];
        ext_q <= wdata_i[EXT_BIT];
      end
      if (wr_ok && addr_i == ADDR_W'(ADR_CTRL)) dlc_q <= wdata_i[DLC_W-1:0];
    end
  end

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) data_q[g*REG_W +: REG_W] <= '0;
      else if (wr_ok && addr_i == ADDR_W'(ADR_DATA + g))
        data_q[g*REG_W +: REG_W] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(ADR_CMD)) rdata_o[0] = busy_i;
    if (addr_i == ADDR_W'(ADR_ID)) begin
      rdata_o[ID_W-1:0] = id_q;
      rdata_o[EXT_BIT]  = ext_q;
    end
    if (addr_i == ADDR_W'(ADR_CTRL)) rdata_o[DLC_W-1:0] = dlc_q;
    for (int k = 0; k < NWORDS; k++)
      if (addr_i == ADDR_W'(ADR_DATA + k)) rdata_o = data_q[k*REG_W +: REG_W];
  end

  assign id_o   = id_q;
  assign ext_o  = ext_q;
  assign dlc_o  = dlc_q;
  assign data_o = data_q;
endmodule

// File: rtl/can_txb_fsm.sv
module can_txb_fsm
  import can_txb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic basic_i,
  input  logic set_req_i,
  input  logic abort_req_i,
  input  logic bus_idle_i,
  input  logic done_i,
  input  logic arb_lost_i,
  input  logic err_i,
  output logic busy_o,
  output logic locked_o,
  output logic load_o
);
  tx_state_e state_q, state_d;
  logic      busy_q, busy_d;
  logic      outcome;

  assign outcome = done_i || arb_lost_i || err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      busy_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      busy_q  <= busy_d;
    end
  end

  always_comb begin
    state_d = state_q;
    busy_d  = busy_q;
    load_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (set_req_i && basic_i) begin
        state_d = ST_WAIT;
        busy_d  = 1'b1;
      end
      ST_WAIT: begin
        if (abort_req_i) begin
          state_d = ST_IDLE;
          busy_d  = 1'b0;
        end else if (bus_idle_i && basic_i) begin
          load_o  = 1'b1;
          state_d = ST_BUS;
        end
      end
      ST_BUS: begin
        if (abort_req_i) begin
          // frame on the wire finishes; only the lock waits for it
          busy_d  = 1'b0;
          state_d = outcome ? ST_IDLE : ST_DRAIN;
        end else if (done_i) begin
          busy_d  = 1'b0;
          state_d = ST_IDLE;
        end else if (arb_lost_i || err_i) begin
          state_d = ST_WAIT;
        end
      end
      ST_DRAIN: if (outcome) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign busy_o   = busy_q;
  assign locked_o = (state_q != ST_IDLE);
endmodule

// File: rtl/can_txb_ctrl.sv
module can_txb_ctrl
  import can_txb_pkg::*;
#(
  parameter int unsigned REG_W  = 32,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned ID_W   = 29,
  parameter int unsigned DLC_W  = 4,
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              basic_mode_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              bus_idle_i,
  output logic              load_o,
  output logic [ID_W-1:0]   tx_id_o,
  output logic              tx_ext_o,
  output logic [DLC_W-1:0]  tx_dlc_o,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic              done_i,
  input  logic              arb_lost_i,
  input  logic              err_i,
  output logic              busy_o,
  output logic              locked_o
);
  logic cmd_wr, set_req, abort_req;

  assign cmd_wr    = reg_wr_i && (reg_addr_i == ADDR_W'(ADR_CMD));
  assign set_req   = cmd_wr && reg_wdata_i[0];
  assign abort_req = cmd_wr && !reg_wdata_i[0];

  can_txb_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .basic_i    (basic_mode_i),
    .set_req_i  (set_req),
    .abort_req_i(abort_req),
    .bus_idle_i (bus_idle_i),
    .done_i     (done_i),
    .arb_lost_i (arb_lost_i),
    .err_i      (err_i),
    .busy_o     (busy_o),
    .locked_o   (locked_o),
    .load_o     (load_o)
  );

  can_txb_regs #(
    .REG_W (REG_W),
    .ADDR_W(ADDR_W),
    .ID_W  (ID_W),
    .DLC_W (DLC_W),
    .DATA_W(DATA_W)
  ) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (reg_wr_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .lock_i (locked_o),
    .busy_i (busy_o),
    .rdata_o(reg_rdata_o),
    .id_o   (tx_id_o),
    .ext_o  (tx_ext_o),
    .dlc_o  (tx_dlc_o),
    .data_o (tx_data_o)
  );
endmodule

// File: rtl/can_txb_checker.sv
module can_txb_checker
  import can_txb_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned ID_W   = 29,
  parameter int unsigned DLC_W  = 4,
  parameter int unsigned DATA_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              basic_mode_i,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              cmd_bit_i,
  input logic              bus_idle_i,
  input logic              done_i,
  input logic              arb_lost_i,
  input logic              err_i,
  input logic              load_o,
  input logic              busy_o,
  input logic              locked_o,
  input logic [ID_W-1:0]   tx_id_o,
  input logic [DLC_W-1:0]  tx_dlc_o,
  input logic [DATA_W-1:0] tx_data_o
);
  logic abort_w;
  assign abort_w = reg_wr_i && reg_addr_i == ADDR_W'(ADR_CMD) && !cmd_bit_i;

  AST_BUSY_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> locked_o); // R2
  AST_NO_REQ_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!basic_mode_i && !locked_o) |=> !busy_o); // R2
  AST_BUF_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> ($stable(tx_id_o) && $stable(tx_dlc_o) && $stable(tx_data_o))); // R3
  AST_LOAD_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> (bus_idle_i && basic_mode_i && busy_o)); // R4
  AST_LOAD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o); // R4
  AST_DONE_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && locked_o) |=> (!busy_o && !locked_o)); // R5
  AST_RETRY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((arb_lost_i || err_i) && busy_o && !abort_w) |=> (busy_o && locked_o)); // R6
  AST_ABORT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_w && locked_o) |=> !busy_o); // R8
endmodule

bind can_txb_ctrl can_txb_checker #(
  .ADDR_W(ADDR_W),
  .ID_W  (ID_W),
  .DLC_W (DLC_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .basic_mode_i(basic_mode_i),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .cmd_bit_i   (reg_wdata_i[0]),
  .bus_idle_i  (bus_idle_i),
  .done_i      (done_i),
  .arb_lost_i  (arb_lost_i),
  .err_i       (err_i),
  .load_o      (load_o),
  .busy_o      (busy_o),
  .locked_o    (locked_o),
  .tx_id_o     (tx_id_o),
  .tx_dlc_o    (tx_dlc_o),
  .tx_data_o   (tx_data_o)
);

// File: tb/can_txb_ctrl_bench.sv
module can_txb_ctrl_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        basic = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        bus_idle = 1'b0;
  logic        load;
  logic [28:0] tx_id;
  logic        tx_ext;
  logic [3:0]  tx_dlc;
  logic [63:0] tx_data;
  logic        done = 1'b0, arb = 1'b0, err = 1'b0;
  logic        busy, locked;

  int checks = 0;
  int errors = 0;

  // reference state: 0 idle, 1 waiting, 2 on bus, 3 draining after abort
  int          m_st = 0;
  logic        m_busy = 1'b0;
  logic [28:0] m_id = '0;
  logic        m_ext = 1'b0;
  logic [3:0]  m_dlc = '0;
  logic [63:0] m_data = '0;

  always #(CLK_P/2) clk = ~clk;

  can_txb_ctrl u_can_txb_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .basic_mode_i(basic),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .bus_idle_i(bus_idle), .load_o(load),
    .tx_id_o(tx_id), .tx_ext_o(tx_ext), .tx_dlc_o(tx_dlc), .tx_data_o(tx_data),
    .done_i(done), .arb_lost_i(arb), .err_i(err),
    .busy_o(busy), .locked_o(locked)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_load(input logic wr, input logic [2:0] a,
                                    input logic [31:0] d, input logic idle);
    logic ab;
    ab = wr && a == 3'd0 && !d[0];
    return (m_st == 1) && idle && basic && !ab;
  endfunction

  function automatic logic [31:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return {31'd0, m_busy};
      3'd1: return {1'b0, m_ext, 1'b0, m_id};
      3'd2: return {28'd0, m_dlc};
      3'd3: return m_data[31:0];
      3'd4: return m_data[63:32];
      default: return 32'd0;
    endcase
  endfunction

  task automatic model(input logic wr, input logic [2:0] a, input logic [31:0] d,
                       input logic idle, input logic dn, input logic al, input logic er);
    logic set, ab, ev;
    set = wr && a == 3'd0 && d[0];
    ab  = wr && a == 3'd0 && !d[0];
    ev  = dn || al || er;
    if (wr && m_st == 0) begin
      if (a == 3'd1) begin m_id = d[28:0]; m_ext = d[30]; end
      if (a == 3'd2) m_dlc = d[3:0];
      if (a == 3'd3) m_data[31:0] = d;
      if (a == 3'd4) m_data[63:32] = d;
    end
    case (m_st)
      0: if (set && basic) begin m_st = 1; m_busy = 1'b1; end
      1: if (ab) begin m_st = 0; m_busy = 1'b0; end
         else if (idle && basic) m_st = 2;
      2: if (ab) begin m_busy = 1'b0; m_st = ev ? 0 : 3; end
         else if (dn) begin m_busy = 1'b0; m_st = 0; end
         else if (al || er) m_st = 1;
      3: if (ev) m_st = 0;
      default: m_st = 0;
    endcase
  endtask

  task automatic tick(input logic wr, input logic [2:0] a, input logic [31:0] d,
                      input logic idle, input logic dn, input logic al, input logic er);
    logic el;
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    bus_idle = idle; done = dn; arb = al; err = er;
    #1;
    el = exp_load(wr, a, d, idle);
    chk(load === el, "R4", "load strobe", 64'(load), 64'(el));
    @(posedge clk);
    model(wr, a, d, idle, dn, al, er);
    #(CLK_P/4);
    chk(busy === m_busy, "R2", "busy flag", 64'(busy), 64'(m_busy));
    chk(locked === (m_st != 0), "R3", "lock", 64'(locked), 64'(m_st != 0));
    chk({tx_ext, tx_dlc, tx_id} === {m_ext, m_dlc, m_id} && tx_data === m_data,
        "R4", "frame fields", 64'(tx_id), 64'(m_id));
  endtask

  task automatic rd(input logic [2:0] a, input string req);
    logic [31:0] e;
    tick(1'b0, a, 32'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    e = exp_read(a);
    chk(reg_rdata === e, req, "read back", 64'(reg_rdata), 64'(e));
  endtask

  // one-cycle outcome pulse with all other inputs quiet
  task automatic pulse(input logic dn, input logic al, input logic er);
    tick(1'b0, 3'd5, 32'd0, 1'b0, dn, al, er);
  endtask

  initial begin
    void'($urandom(32'h5EED_CA11));
    repeat (3) @(negedge clk);
    #1;
    chk(busy === 1'b0 && locked === 1'b0 && load === 1'b0, "R1", "reset outputs",
        64'({busy, locked, load}), 64'd0);
    rst_n = 1'b1;
    for (int k = 0; k < 5; k++) begin
      reg_addr = 3'(k); #1;
      chk(reg_rdata === 32'd0, "R1", "reset register", 64'(reg_rdata), 64'd0);
    end

    // R2: request ignored outside basic mode
    basic = 1'b0;
    tick(1'b1, 3'd0, 32'd1, 1'b1, 1'b0, 1'b0, 1'b0);
    chk(busy === 1'b0, "R2", "request without basic mode", 64'(busy), 64'd0);
    basic = 1'b1;

    // R9: clearing an already clear busy flag
    tick(1'b1, 3'd0, 32'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk(busy === 1'b0 && locked === 1'b0, "R9", "clear when idle", 64'(busy), 64'd0);

    // R3: fill the buffer while unlocked
    tick(1'b1, 3'd1, 32'h4ABC_1234, 1'b0, 1'b0, 1'b0, 1'b0);
    tick(1'b1, 3'd2, 32'h0000_0008, 1'b0, 1'b0, 1'b0, 1'b0);
    tick(1'b1, 3'd3, 32'hDEAD_BEEF, 1'b0, 1'b0, 1'b0, 1'b0);
    tick(1'b1, 3'd4, 32'h0BAD_F00D, 1'b0, 1'b0, 1'b0, 1'b0);
    rd(3'd1, "R3");
    rd(3'd4, "R3");

    // R2/R3: request locks; locked write dropped
    tick(1'b1, 3'd0, 32'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(busy === 1'b1 && locked === 1'b1, "R2", "request sets busy", 64'(busy), 64'd1);
    tick(1'b1, 3'd1, 32'h1111_1111, 1'b0, 1'b0, 1'b0, 1'b0);
    rd(3'd1, "R3");
    chk(tx_id === 29'h0ABC_1234, "R3", "locked id unchanged", 64'(tx_id), 64'h0ABC1234);

    // R4: load on idle
    tick(1'b0, 3'd5, 32'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    // R9: set again while on bus: nothing
    tick(1'b1, 3'd0, 32'd1, 1'b1, 1'b0, 1'b0, 1'b0);
    chk(load === 1'b0, "R9", "no second load", 64'(load), 64'd0);
    // R6: arbitration lost then retry
    pulse(1'b0, 1'b1, 1'b0);
    chk(busy === 1'b1 && locked === 1'b1, "R6", "busy after arb loss", 64'(busy), 64'd1);
    tick(1'b0, 3'd5, 32'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk(m_st == 2, "R6", "retry loaded", 64'(m_st), 64'd2);
    pulse(1'b0, 1'b0, 1'b1);
    tick(1'b0, 3'd5, 32'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    // R5: done frees
    pulse(1'b1, 1'b0, 1'b0);
    chk(busy === 1'b0 && locked === 1'b0, "R5", "done clears", 64'({busy, locked}), 64'd0);

    // R7: abort in the bus-idle cycle
    tick(1'b1, 3'd0, 32'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    tick(1'b1, 3'd0, 32'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk(busy === 1'b0 && locked === 1'b0, "R7", "abort before load", 64'({busy, locked}), 64'd0);

    // R8: abort mid-frame, lock held until outcome
    tick(1'b1, 3'd0, 32'd1, 1'b1, 1'b0, 1'b0, 1'b0);
    tick(1'b0, 3'd5, 32'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    tick(1'b1, 3'd0, 32'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk(busy === 1'b0 && locked === 1'b1, "R8", "abort on bus", 64'({busy, locked}), 64'd1);
    tick(1'b0, 3'd5, 32'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    pulse(1'b0, 1'b0, 1'b1);
    chk(locked === 1'b0, "R8", "unlock after error", 64'(locked), 64'd0);
    tick(1'b0, 3'd5, 32'd0, 1'b1, 1'b0, 1'b0, 1'b0);

    // R10: abort in the arbitration-lost cycle
    tick(1'b1, 3'd0, 32'd1, 1'b1, 1'b0, 1'b0, 1'b0);
    tick(1'b0, 3'd5, 32'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    tick(1'b1, 3'd0, 32'd0, 1'b1, 1'b0, 1'b1, 1'b0);
    chk(busy === 1'b0 && locked === 1'b0, "R10", "abort with arb loss",
        64'({busy, locked}), 64'd0);
    tick(1'b0, 3'd5, 32'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk(load === 1'b0, "R10", "no retry after abort", 64'(load), 64'd0);

    // constrained random with collisions
    for (int i = 0; i < 4000; i++) begin
      logic wr, idle, dn, al, er;
      logic [2:0] a;
      logic [31:0] d;
      int ev;
      if ($urandom_range(0, 49) == 0) basic = ~basic;
      wr   = ($urandom_range(0, 3) == 0);
      a    = ($urandom_range(0, 1) == 0) ? 3'd0 : 3'($urandom_range(1, 4));
      d    = $urandom();
      idle = ($urandom_range(0, 2) == 0);
      dn = 1'b0; al = 1'b0; er = 1'b0;
      if (m_st >= 2) begin
        ev = $urandom_range(0, 7);
        dn = (ev == 0); al = (ev == 1); er = (ev == 2);
      end
      tick(wr, a, d, idle, dn, al, er);
      if (!wr && $urandom_range(0, 7) == 0)
        chk(reg_rdata === exp_read(a), "R3", "random read", 64'(reg_rdata), 64'(exp_read(a)));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule